// File: doc/BRIEF.md
# Clear-on-Compare Interval Timer

This block is a 16-bit up-counting timer that sits on an 8-bit register bus. A clock-select field decides where the counter's ticks come from. The counter can be stopped, or it can count the system clock either directly or through a power-of-two prescaler. In clear-on-compare mode, the counter climbs until it equals a programmed top value and then drops back to zero on the next tick. Each time that happens, the block emits one event.

Every compare match raises a sticky match flag. A mask bit gates the flag onto the interrupt request output. A match that arrives while the mask is off stays pending, and the request appears once software sets the mask. The flag is cleared in one of two ways: the interrupt controller pulses an acknowledge, or software writes a one to the flag bit.

The counter and the top value are both 16 bits wide and are reached as two bytes. Software writes the high byte first. That byte waits in a staging latch shared by both registers. The following low-byte write commits the whole word in one cycle, so the counter logic never sees a half-written value. The usual use is a periodic tick. For example, with an 8 MHz clock, divide-by-8 and a top of 999, the block produces an interrupt every millisecond.

Top module: `cmp_tick_timer`

## Requirements
- R1: After reset, every register reads 0x00 and `irq` is low. The register map is: control at address 0, mask at 1, flag at 2, counter low/high at 3/4, top low/high at 5/6. Unused addresses read 0x00.
- R2: Control bits [2:0] select the tick source. The codes are: 000 stopped, 001 every clock, 010 every 8th clock, 011 every 64th, 100 every 256th, 101 every 1024th. Codes 110 and 111 also stop the counter. With the source stopped, the counter holds its value.
- R3: Control bit 4 = 0 together with bit 3 = 1 selects clear-on-compare mode. In this mode a tick that finds the count equal to top loads zero, and every other tick adds one. The match period is therefore (top+1) ticks.
- R4: With any other value in control bits [4:3], the counter ignores top when deciding to wrap. It adds one per tick and rolls from 0xFFFF to 0x0000.
- R5: In any mode, a tick that finds the count equal to top sets the match flag, which reads as bit 1 of the flag register.
- R6: `irq` is high exactly while the match flag and mask bit 1 are both set. A flag set while masked persists, and `irq` rises in the cycle after the mask bit is written to 1.
- R7: The flag clears in the cycle after `irq_ack` is high, or after a write to the flag register with bit 1 = 1. Writing 0 to bit 1 leaves the flag alone. A match in the same cycle as a clear keeps the flag set.
- R8: A write to either high-byte address (4 or 6) only loads the shared staging byte. A write to a low-byte address (3 or 5) loads that register with {staging byte, written byte} in one cycle.
- R9: A control write with bits [2:0] = 000 restarts the prescaler from zero. The first tick after the next start therefore comes after a full divide interval.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| addr | input | 3 | Register address for writes and reads |
| wdata | input | 8 | Write data byte |
| rdata | output | 8 | Read data for `addr` (combinational) |
| irq_ack | input | 1 | Interrupt acknowledge, clears the match flag |
| irq | output | 1 | Interrupt request: match flag gated by the mask bit |

## Verification
The properties sample the write strobe, address, data and acknowledge only at rising edges. They assume that an acknowledge never coincides with a fresh match when they claim that the flag is cleared. The stimulus changes every input on falling edges and always writes 16-bit values as a high byte followed by a low byte. It holds the acknowledge for exactly one cycle and chooses match periods of at least two clocks wherever it acknowledges, so that the assumed separation holds. The one case that deliberately lets a clear and a match collide uses a register write rather than the acknowledge. Its purpose is to show that the set wins.

// File: rtl/ctt_pkg.sv
package ctt_pkg;

    localparam int CNT_W  = 16;
    localparam int ADDR_W = 3;
    localparam int PRE_W  = 10;   // widest divide is 1024
    localparam int IE_BIT = 1;    // interrupt enable bit in the mask register
    localparam int FLG_BIT = 1;   // match flag bit in the flag register

    typedef enum logic [ADDR_W-1:0] {
        R_CTRL   = 3'd0,
        R_MASK   = 3'd1,
        R_FLAG   = 3'd2,
        R_CNT_LO = 3'd3,
        R_CNT_HI = 3'd4,
        R_TOP_LO = 3'd5,
        R_TOP_HI = 3'd6
    } reg_sel_e;

    typedef enum logic [1:0] {
        WM_FREE = 2'b00,
        WM_CTC  = 2'b01,   // upper bit 0, lower bit 1
        WM_RSV2 = 2'b10,
        WM_RSV3 = 2'b11
    } wave_mode_e;

    typedef enum logic [2:0] {
        CS_OFF     = 3'd0,
        CS_DIV1    = 3'd1,
        CS_DIV8    = 3'd2,
        CS_DIV64   = 3'd3,
        CS_DIV256  = 3'd4,
        CS_DIV1024 = 3'd5,
        CS_RSV6    = 3'd6,
        CS_RSV7    = 3'd7
    } clk_sel_e;

    // Low prescaler bits that must all be ones for a tick to fire.
    function automatic logic [PRE_W-1:0] div_mask(input clk_sel_e cs);
        logic [PRE_W-1:0] m;
        case (cs)
            CS_DIV8:    m = PRE_W'(7);
            CS_DIV64:   m = PRE_W'(63);
            CS_DIV256:  m = PRE_W'(255);
            CS_DIV1024: m = PRE_W'(1023);
            default:    m = '0;
        endcase
        return m;
    endfunction

    function automatic logic cs_active(input clk_sel_e cs);
        return (cs == CS_DIV1) || (cs == CS_DIV8) || (cs == CS_DIV64) ||
               (cs == CS_DIV256) || (cs == CS_DIV1024);
    endfunction

endpackage

// File: rtl/ctt_prescaler.sv
module ctt_prescaler
    import ctt_pkg::*;
#(
    parameter int PW = ctt_pkg::PRE_W
) (
    input  logic     clk,
    input  logic     rst_n,
    input  clk_sel_e cs,
    input  logic     restart,
    output logic     tick
);

    typedef struct packed {
        logic [PW-1:0] pre;
    } pre_t;

    pre_t s_d, s_q;
    logic active;
    logic [PW-1:0] mask;

    always_comb begin
        active = cs_active(cs);
        mask   = PW'(div_mask(cs));
        s_d    = s_q;
        if (restart) begin
            s_d.pre = '0;
        end else if (active) begin
            s_d.pre = s_q.pre + 1'b1;
        end
        tick = active && ((s_q.pre & mask) == mask);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

endmodule

// File: rtl/ctt_regs.sv
module ctt_regs
    import ctt_pkg::*;
#(
    parameter int CNT_W = ctt_pkg::CNT_W,
    localparam int HALF_W = CNT_W / 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [HALF_W-1:0]  wdata,
    output clk_sel_e           cs_o,
    output wave_mode_e         mode_o,
    output logic               ie_o,
    output logic [CNT_W-1:0]   top_o,
    output logic               cnt_ld_o,
    output logic [CNT_W-1:0]   cnt_ld_val_o,
    output logic               flag_clr_o,
    output logic               pre_restart_o
);

    typedef struct packed {
        clk_sel_e          cs;
        wave_mode_e        mode;
        logic              ie;
        logic [CNT_W-1:0]  top;
        logic [HALF_W-1:0] stage;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d           = r_q;
        cnt_ld_o      = 1'b0;
        cnt_ld_val_o  = {r_q.stage, wdata};
        flag_clr_o    = 1'b0;
        pre_restart_o = 1'b0;
        if (wr_en) begin
            case (reg_sel_e'(addr))
                R_CTRL: begin
                    r_d.cs        = clk_sel_e'(wdata[2:0]);
                    r_d.mode      = wave_mode_e'(wdata[4:3]);
                    pre_restart_o = (wdata[2:0] == CS_OFF);
                end
                R_MASK:   r_d.ie     = wdata[IE_BIT];
                R_FLAG:   flag_clr_o = wdata[FLG_BIT];
                R_CNT_HI: r_d.stage  = wdata;
                R_TOP_HI: r_d.stage  = wdata;
                R_CNT_LO: cnt_ld_o   = 1'b1;
                R_TOP_LO: r_d.top    = {r_q.stage, wdata};
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{cs: CS_OFF, mode: WM_FREE, ie: 1'b0, top: '0, stage: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign cs_o   = r_q.cs;
    assign mode_o = r_q.mode;
    assign ie_o   = r_q.ie;
    assign top_o  = r_q.top;

endmodule

// File: rtl/ctt_core.sv
module ctt_core #(
    parameter int CNT_W = ctt_pkg::CNT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             ctc,
    input  logic [CNT_W-1:0] top,
    input  logic             ld,
    input  logic [CNT_W-1:0] ld_val,
    input  logic             flag_clr,
    output logic [CNT_W-1:0] cnt_o,
    output logic             flag_o
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             flag;
    } core_t;

    core_t c_d, c_q;
    logic  hit;

    always_comb begin
        hit = tick && (c_q.cnt == top);
        c_d = c_q;
        if (ld) begin
            c_d.cnt = ld_val;
        end else if (tick) begin
            if (hit && ctc) begin
                c_d.cnt = '0;
            end else begin
                c_d.cnt = c_q.cnt + 1'b1;
            end
        end
        // a fresh match outranks any clear in the same cycle
        if (hit) begin
            c_d.flag = 1'b1;
        end else if (flag_clr) begin
            c_d.flag = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q <= '0;
        end else begin
            c_q <= c_d;
        end
    end

    assign cnt_o  = c_q.cnt;
    assign flag_o = c_q.flag;

endmodule

// File: rtl/cmp_tick_timer.sv
module cmp_tick_timer
    import ctt_pkg::*;
#(
    parameter int CNT_W = ctt_pkg::CNT_W,
    localparam int HALF_W = CNT_W / 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [HALF_W-1:0] wdata,
    output logic [HALF_W-1:0] rdata,
    input  logic              irq_ack,
    output logic              irq
);

    clk_sel_e         cs_sel;
    wave_mode_e       mode;
    logic             ie;
    logic [CNT_W-1:0] top_val;
    logic             cnt_ld;
    logic [CNT_W-1:0] cnt_ld_val;
    logic             flag_clr_wr;
    logic             pre_restart;
    logic             tick;
    logic             ctc;
    logic [CNT_W-1:0] cnt;
    logic             flag;

    ctt_regs #(.CNT_W(CNT_W)) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en        (wr_en),
        .addr         (addr),
        .wdata        (wdata),
        .cs_o         (cs_sel),
        .mode_o       (mode),
        .ie_o         (ie),
        .top_o        (top_val),
        .cnt_ld_o     (cnt_ld),
        .cnt_ld_val_o (cnt_ld_val),
        .flag_clr_o   (flag_clr_wr),
        .pre_restart_o(pre_restart)
    );

    ctt_prescaler #(.PW(PRE_W)) u_pre (
        .clk    (clk),
        .rst_n  (rst_n),
        .cs     (cs_sel),
        .restart(pre_restart),
        .tick   (tick)
    );

    assign ctc = (mode == WM_CTC);

    ctt_core #(.CNT_W(CNT_W)) u_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .ctc     (ctc),
        .top     (top_val),
        .ld      (cnt_ld),
        .ld_val  (cnt_ld_val),
        .flag_clr(flag_clr_wr | irq_ack),
        .cnt_o   (cnt),
        .flag_o  (flag)
    );

    always_comb begin
        rdata = '0;
        case (reg_sel_e'(addr))
            R_CTRL:   rdata = {{(HALF_W-5){1'b0}}, mode, cs_sel};
            R_MASK:   rdata[IE_BIT]  = ie;
            R_FLAG:   rdata[FLG_BIT] = flag;
            R_CNT_LO: rdata = cnt[HALF_W-1:0];
            R_CNT_HI: rdata = cnt[CNT_W-1:HALF_W];
            R_TOP_LO: rdata = top_val[HALF_W-1:0];
            R_TOP_HI: rdata = top_val[CNT_W-1:HALF_W];
            default: ;
        endcase
    end

    assign irq = flag & ie;

endmodule

// File: rtl/cmp_tick_timer_chk.sv
module cmp_tick_timer_chk
    import ctt_pkg::*;
#(
    parameter int CNT_W = ctt_pkg::CNT_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic              wbit1,
    input logic              irq_ack,
    input logic              irq,
    input logic              tick,
    input logic              ctc,
    input logic [CNT_W-1:0]  cnt_q,
    input logic [CNT_W-1:0]  top_q,
    input logic              flag,
    input logic              ie,
    input logic [2:0]        cs
);

    logic ld_w, flag_w, mask_w, toph_w, hit;
    assign ld_w   = wr_en && (addr == R_CNT_LO);
    assign flag_w = wr_en && (addr == R_FLAG) && wbit1;
    assign mask_w = wr_en && (addr == R_MASK) && wbit1;
    assign toph_w = wr_en && (addr == R_TOP_HI);
    assign hit    = tick && (cnt_q == top_q);

    // R2: a stopped source leaves the count unchanged
    a_r2_stopped_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (cs == 3'd0 && !ld_w) |=> $stable(cnt_q));

    // R3: the counter returns to zero after a match in clear-on-compare mode
    a_r3_ctc_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && ctc && !ld_w) |=> (cnt_q == '0));

    // R4: outside clear-on-compare mode each tick adds one
    a_r4_free_step: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !ctc && !ld_w) |=> (cnt_q == $past(cnt_q) + 1'b1));

    // R5: a match sets the flag
    a_r5_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> flag);

    // R6: the flag stays pending without a clear
    a_r6_flag_held: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !irq_ack && !flag_w) |=> flag);

    // R6: setting the mask over a pending flag raises the request
    a_r6_deferred_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !ie && mask_w && !irq_ack) |=> irq);

    // R7: acknowledge clears the flag unless a match collides
    a_r7_ack_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ack && !hit) |=> !flag);

    // R8: a high-byte write leaves the top register untouched
    a_r8_high_staged: assert property (@(posedge clk) disable iff (!rst_n)
        toph_w |=> $stable(top_q));

endmodule

bind cmp_tick_timer cmp_tick_timer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_en),
    .addr   (addr),
    .wbit1  (wdata[1]),
    .irq_ack(irq_ack),
    .irq    (irq),
    .tick   (tick),
    .ctc    (ctc),
    .cnt_q  (cnt),
    .top_q  (top_val),
    .flag   (flag),
    .ie     (ie),
    .cs     (cs_sel)
);

// File: tb/cmp_tick_timer_test.sv
module cmp_tick_timer_test;

    localparam int A_CTRL = 0, A_MASK = 1, A_FLAG = 2;
    localparam int A_CLO = 3, A_CHI = 4, A_TLO = 5, A_THI = 6;
    localparam logic [7:0] M_CTC = 8'h08;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       irq_ack = 1'b0;
    logic       irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        string tag;
        int    val;
    } item_t;

    item_t exp_q[$];
    int    act_q[$];

    always #4 clk = ~clk;

    cmp_tick_timer uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .irq_ack(irq_ack), .irq(irq)
    );

    // monitor: pops expected and observed items and compares them
    initial begin
        forever begin
            @(posedge clk);
            while (act_q.size() > 0 && exp_q.size() > 0) begin
                item_t e;
                int    a;
                e = exp_q.pop_front();
                a = act_q.pop_front();
                checks++;
                if (a != e.val) begin
                    errors++;
                    $display("FAIL %s: actual 0x%0h expected 0x%0h", e.tag, a, e.val);
                end
            end
        end
    end

    task automatic expect_val(input string tag, input int v);
        exp_q.push_back('{tag, v});
    endtask

    task automatic observe(input int v);
        act_q.push_back(v);
    endtask

    task automatic wr(input int a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1;
        addr  = 3'(a);
        wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input int a, output logic [7:0] v);
        addr = 3'(a);
        #1;
        v = rdata;
    endtask

    task automatic chk_reg(input string tag, input int a, input int v);
        logic [7:0] x;
        expect_val(tag, v);
        rd(a, x);
        observe(int'(x));
    endtask

    task automatic chk_irq(input string tag, input int v);
        expect_val(tag, v);
        #1;
        observe(int'(irq));
    endtask

    task automatic set16(input int hi, input int lo, input logic [15:0] v);
        wr(hi, v[15:8]);
        wr(lo, v[7:0]);
    endtask

    // start the source, wait k falling edges, stop it: k+2 clock edges of running
    task automatic run(input logic [7:0] mode_bits, input logic [2:0] cs, input int k);
        wr(A_CTRL, mode_bits | {5'b0, cs});
        repeat (k) @(negedge clk);
        wr(A_CTRL, mode_bits);
    endtask

    task automatic measure(input string tag, input int top, input logic [2:0] cs, input int div);
        int n;
        wr(A_CTRL, M_CTC);
        set16(A_CHI, A_CLO, 16'h0000);
        set16(A_THI, A_TLO, 16'(top));
        wr(A_MASK, 8'h02);
        wr(A_FLAG, 8'h02);
        expect_val(tag, (top + 1) * div);
        wr(A_CTRL, M_CTC | {5'b0, cs});
        n = 0;
        while (!irq && n < 20000) begin
            @(negedge clk);
            n++;
        end
        irq_ack = 1'b1;
        n = 0;
        do begin
            @(negedge clk);
            irq_ack = 1'b0;
            n++;
        end while (!irq && n < 20000);
        observe(n);
        wr(A_CTRL, M_CTC);
        wr(A_FLAG, 8'h02);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset values
        chk_reg("R1 ctrl reset", A_CTRL, 0);
        chk_reg("R1 mask reset", A_MASK, 0);
        chk_reg("R1 flag reset", A_FLAG, 0);
        chk_reg("R1 count reset", A_CLO, 0);
        chk_reg("R1 top reset", A_THI, 0);
        chk_reg("R1 unused address", 7, 0);
        chk_irq("R1 irq reset", 0);

        // R8: staged high byte, shared between registers
        wr(A_THI, 8'h12);
        chk_reg("R8 top high not yet committed", A_THI, 8'h00);
        wr(A_TLO, 8'h34);
        chk_reg("R8 top high committed", A_THI, 8'h12);
        chk_reg("R8 top low committed", A_TLO, 8'h34);
        wr(A_CHI, 8'hAB);
        wr(A_TLO, 8'h56);
        chk_reg("R8 shared staging byte", A_THI, 8'hAB);
        chk_reg("R8 count untouched by top write", A_CLO, 0);

        // R4/R5: free-running mode passes top without wrapping but flags it
        wr(A_FLAG, 8'h02);
        set16(A_THI, A_TLO, 16'd2);
        set16(A_CHI, A_CLO, 16'd0);
        run(8'h00, 3'd1, 8);
        chk_reg("R4 free count past top", A_CLO, 10);
        chk_reg("R5 flag set in free mode", A_FLAG, 8'h02);
        set16(A_CHI, A_CLO, 16'hFFFE);
        run(8'h00, 3'd1, 1);
        chk_reg("R4 rollover low", A_CLO, 1);
        chk_reg("R4 rollover high", A_CHI, 0);

        // R2: reserved code stops the counter
        set16(A_CHI, A_CLO, 16'd5);
        run(8'h00, 3'd6, 20);
        chk_reg("R2 reserved code holds", A_CLO, 5);

        // R2/R9: divide by 8 and prescaler restart on stop
        set16(A_CHI, A_CLO, 16'd0);
        set16(A_THI, A_TLO, 16'hFFFF);
        run(8'h00, 3'd2, 10);
        chk_reg("R2 divide by 8 tick count", A_CLO, 1);
        run(8'h00, 3'd2, 10);
        chk_reg("R9 prescaler restarted", A_CLO, 2);

        // R3/R6/R7: masked match, deferred request, clears
        wr(A_MASK, 8'h00);
        wr(A_FLAG, 8'h02);
        set16(A_CHI, A_CLO, 16'd0);
        set16(A_THI, A_TLO, 16'd3);
        run(M_CTC, 3'd1, 8);
        chk_reg("R3 count after wraps", A_CLO, 2);
        chk_irq("R6 masked no request", 0);
        chk_reg("R6 flag pending", A_FLAG, 8'h02);
        wr(A_FLAG, 8'h00);
        chk_reg("R7 write zero ignored", A_FLAG, 8'h02);
        wr(A_MASK, 8'h02);
        chk_irq("R6 deferred request", 1);
        @(negedge clk);
        irq_ack = 1'b1;
        @(negedge clk);
        irq_ack = 1'b0;
        chk_irq("R7 ack clears request", 0);
        chk_reg("R7 ack clears flag", A_FLAG, 0);
        run(M_CTC, 3'd1, 8);
        chk_irq("R6 request on new match", 1);
        wr(A_FLAG, 8'h02);
        chk_irq("R7 write one clears", 0);

        // R7: match in the same cycle as a clear wins
        wr(A_MASK, 8'h00);
        set16(A_CHI, A_CLO, 16'd0);
        set16(A_THI, A_TLO, 16'd0);
        wr(A_CTRL, M_CTC | 8'h01);
        wr(A_FLAG, 8'h02);
        chk_reg("R7 set beats clear", A_FLAG, 8'h02);
        wr(A_CTRL, M_CTC);

        // R3: match period for several top values and dividers
        measure("R3 period top 3 div 1", 3, 3'd1, 1);
        measure("R3 period top 9 div 8", 9, 3'd2, 8);
        measure("R3 period top 0 div 8", 0, 3'd2, 8);
        measure("R3 period top 5 div 64", 5, 3'd3, 64);
        measure("R3 period top 999 div 8", 999, 3'd2, 8);

        repeat (3) @(posedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule